// File: doc/BRIEF.md
# Low-Power Timer Control Register Wrapper

This block is the register front end of a low-power counter. Software reaches it over a plain address/data bus. It holds the timer enable, the continuous-run start bit, the counting configuration (quadrature mode and edge select), the auto-reload ceiling and the compare value. The counting datapath sits outside the block. It receives a single count-enable output, the configuration and the two loaded values.

The reload and compare registers accept a new value only while the timer is enabled. An accepted value does not land at once. It crosses a modelled transfer window of `XFER_CYCLES` clocks (three by default). When the window ends, the value commits and a sticky "write OK" flag is raised for that register. Software polls the flags, clears them by writing ones to a separate clear address, and then sets the start bit.

The start bit is honoured only once the timer is enabled and a reload transfer has completed since that enable. Dropping the enable bit stops everything: it clears the start bit and the flags, and cancels any transfer in flight.

Top module: `timer_ctl`

## Requirements
- R1: After reset the enable bit, start bit, both OK flags, `countEn`, `quadMode` and `edgeSel` are 0. `reloadVal` is all ones and `compareVal` is 0.
- R2: Writes to the reload register (address 2) or the compare register (address 3) while the timer is disabled are ignored. The value does not change and no OK flag is set.
- R3: When a reload or compare write is accepted at clock edge T, the new value appears on its output and its OK flag rises exactly at edge T+3, and not earlier.
- R4: A second write to the same register at edges T+1 to T+3 of a pending transfer is ignored. A write at edge T+4 or later is accepted. Transfers to the reload and compare registers proceed independently.
- R5: The OK flags are sticky. Writing to the clear register (address 5) clears each flag whose bit is 1 in the write data and leaves the flags whose bit is 0 unchanged.
- R6: The control register (address 0) holds enable in bit 0 and start in bit 1. The start bit is set only if the timer is already enabled and a reload transfer has completed since that enable. `countEn` is high exactly when enable and start are both set.
- R7: The configuration register (address 1) holds `quadMode` in bit 0 and `edgeSel` in bits 2:1. Writes to it are accepted while disabled and ignored while enabled.
- R8: Writing 0 to enable bit 0 clears enable, start, both OK flags and the reload-loaded state. It also cancels pending transfers, so their values never commit.
- R9: The status register (address 4) and the `okStatus` port show the reload OK flag in bit 0 and the compare OK flag in bit 1. The clear register uses the same bit positions. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 3 | Register address for writes and reads |
| busWdata | input | W | Write data |
| busRdata | output | W | Read data for `busAddr` (combinational) |
| okStatus | output | 2 | Reload OK (bit 0) and compare OK (bit 1) flags |
| countEn | output | 1 | Count enable to the counting datapath |
| quadMode | output | 1 | Quadrature mode select |
| edgeSel | output | 2 | Active edge select |
| reloadVal | output | W | Committed auto-reload ceiling |
| compareVal | output | W | Committed compare value |

## Verification
The transfer window is swept by issuing a second write to the reload register 1 to 5 cycles after the first. The committed value tells a write refused inside the window apart from one accepted after it. Each flag is sampled one edge before and at the edge where it must rise, which separates an off-by-one window from a correct one. Clear writes use the patterns 0, 2 and 1, so a clear that ignores its mask or swaps the bit positions shows up. Disabled-state writes, locked configuration writes, early start requests and a disable during a pending transfer each show whether a guard is missing.

// File: rtl/timer_ctl_pkg.sv
package timer_ctl_pkg;
  localparam int ADDR_W = 3;
  localparam int NCH = 2;
  localparam int CH_RELOAD = 0;
  localparam int CH_CMP = 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMP    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 3'd5;

  // Strobes from control to the transfer datapath
  typedef struct packed {
    logic [NCH-1:0] load;   // start a transfer on that channel
    logic           abort;  // timer being disabled: drop all transfers
  } xferStrobe_t;
endpackage

// File: rtl/timer_ctl_xfer.sv
module timer_ctl_xfer
  import timer_ctl_pkg::*;
#(
  parameter int W = 16,
  parameter int XFER_CYCLES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xferStrobe_t            strobe,
  input  logic [W-1:0]           busWdata,
  output logic [NCH-1:0]         xferBusy,
  output logic [NCH-1:0]         xferDone,
  output logic [NCH-1:0][W-1:0]  regVal
);
  localparam int CW = $clog2(XFER_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(XFER_CYCLES);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [W-1:0] RST_VAL = (ch == CH_RELOAD) ? {W{1'b1}} : {W{1'b0}};
    logic [CW-1:0] cntQ;
    logic [W-1:0]  pendQ;
    logic [W-1:0]  valQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ  <= '0;
        pendQ <= '0;
        valQ  <= RST_VAL;
      end else if (strobe.abort) begin
        cntQ <= '0;
      end else if (strobe.load[ch]) begin
        cntQ  <= CNT_LOAD;
        pendQ <= busWdata;
      end else if (cntQ != '0) begin
        cntQ <= cntQ - CNT_ONE;
        if (cntQ == CNT_ONE) valQ <= pendQ;
      end
    end

    assign xferBusy[ch] = (cntQ != '0);
    assign xferDone[ch] = (cntQ == CNT_ONE) && !strobe.abort;
    assign regVal[ch]   = valQ;
  end
endmodule

// File: rtl/timer_ctl_regs.sv
module timer_ctl_regs
  import timer_ctl_pkg::*;
#(
  parameter int W = 16,
  parameter int EDGE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [EDGE_W:0]   ctlBits,
  input  logic [NCH-1:0]    xferBusy,
  input  logic [NCH-1:0]    xferDone,
  input  logic [W-1:0]      reloadVal,
  input  logic [W-1:0]      compareVal,
  output xferStrobe_t       strobe,
  output logic [W-1:0]      busRdata,
  output logic [NCH-1:0]    okFlags,
  output logic              countEn,
  output logic              timerOn,
  output logic              quadMode,
  output logic [EDGE_W-1:0] edgeSel
);
  logic enQ, startQ, loadedQ, quadQ;
  logic [EDGE_W-1:0] edgeQ;
  logic [NCH-1:0] okQ, okNext;
  logic wrCtrl, wrCfg, wrReload, wrCmp, wrClear, disableReq;

  assign wrCtrl   = busWr && (busAddr == ADDR_CTRL);
  assign wrCfg    = busWr && (busAddr == ADDR_CFG);
  assign wrReload = busWr && (busAddr == ADDR_RELOAD);
  assign wrCmp    = busWr && (busAddr == ADDR_CMP);
  assign wrClear  = busWr && (busAddr == ADDR_CLEAR);
  assign disableReq = wrCtrl && !ctlBits[0];

  always_comb begin
    strobe.abort = disableReq && enQ;
    strobe.load[CH_RELOAD] = wrReload && enQ && !xferBusy[CH_RELOAD];
    strobe.load[CH_CMP]    = wrCmp && enQ && !xferBusy[CH_CMP];
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (xferDone[i])                  okNext[i] = 1'b1;
      else if (wrClear && ctlBits[i])   okNext[i] = 1'b0;
      else                              okNext[i] = okQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      startQ  <= 1'b0;
      loadedQ <= 1'b0;
      okQ     <= '0;
      quadQ   <= 1'b0;
      edgeQ   <= '0;
    end else if (disableReq) begin
      enQ     <= 1'b0;
      startQ  <= 1'b0;
      loadedQ <= 1'b0;
      okQ     <= '0;
    end else begin
      okQ     <= okNext;
      loadedQ <= loadedQ | xferDone[CH_RELOAD];
      if (wrCtrl) begin
        enQ    <= 1'b1;
        startQ <= ctlBits[1] && enQ && loadedQ;
      end
      if (wrCfg && !enQ) begin
        quadQ <= ctlBits[0];
        edgeQ <= ctlBits[EDGE_W:1];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTRL:   busRdata = {{(W-2){1'b0}}, startQ, enQ};
      ADDR_CFG:    busRdata = {{(W-EDGE_W-1){1'b0}}, edgeQ, quadQ};
      ADDR_RELOAD: busRdata = reloadVal;
      ADDR_CMP:    busRdata = compareVal;
      ADDR_STATUS: busRdata = {{(W-NCH){1'b0}}, okQ};
      default:     busRdata = '0;
    endcase
  end

  assign okFlags  = okQ;
  assign countEn  = enQ && startQ;
  assign timerOn  = enQ;
  assign quadMode = quadQ;
  assign edgeSel  = edgeQ;
endmodule

// File: rtl/timer_ctl.sv
module timer_ctl
  import timer_ctl_pkg::*;
#(
  parameter int W = 16,
  parameter int XFER_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [W-1:0]      busWdata,
  output logic [W-1:0]      busRdata,
  output logic [1:0]        okStatus,
  output logic              countEn,
  output logic              quadMode,
  output logic [1:0]        edgeSel,
  output logic [W-1:0]      reloadVal,
  output logic [W-1:0]      compareVal
);
  localparam int EDGE_W = 2;

  xferStrobe_t           strobe;
  logic [NCH-1:0]        xferBusy, xferDone;
  logic [NCH-1:0][W-1:0] regVal;
  logic                  timerOn;

  timer_ctl_regs #(.W(W), .EDGE_W(EDGE_W)) u_regs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .ctlBits(busWdata[EDGE_W:0]), .xferBusy(xferBusy), .xferDone(xferDone),
    .reloadVal(regVal[CH_RELOAD]), .compareVal(regVal[CH_CMP]),
    .strobe(strobe), .busRdata(busRdata), .okFlags(okStatus),
    .countEn(countEn), .timerOn(timerOn), .quadMode(quadMode), .edgeSel(edgeSel)
  );

  timer_ctl_xfer #(.W(W), .XFER_CYCLES(XFER_CYCLES)) u_xfer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .xferBusy(xferBusy), .xferDone(xferDone), .regVal(regVal)
  );

  assign reloadVal  = regVal[CH_RELOAD];
  assign compareVal = regVal[CH_CMP];
endmodule

// File: rtl/timer_ctl_chk.sv
module timer_ctl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         busWr,
  input logic [2:0]   busAddr,
  input logic         wdat0,
  input logic [1:0]   okStatus,
  input logic         countEn,
  input logic         timerOn,
  input logic         quadMode,
  input logic [1:0]   edgeSel,
  input logic [W-1:0] reloadVal
);
  // count only while enabled
  p_no_count_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !timerOn |-> !countEn);

  // disable edge leaves no flag behind
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timerOn) |-> (okStatus == 2'b00));

  // reload never commits across an edge taken while disabled
  p_reload_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(!timerOn) |-> $stable(reloadVal));

  // configuration frozen while enabled
  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(timerOn) |-> $stable({quadMode, edgeSel}));

  // a reload flag only drops through a clear or a disable write
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(okStatus[0]) |->
      $past(busWr && ((busAddr == 3'd5 && wdat0) || (busAddr == 3'd0 && !wdat0))));
endmodule

bind timer_ctl timer_ctl_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .wdat0(busWdata[0]),
  .okStatus(okStatus), .countEn(countEn), .timerOn(timerOn),
  .quadMode(quadMode), .edgeSel(edgeSel), .reloadVal(reloadVal)
);

// File: tb/timer_ctl_tb.sv
`timescale 1ns/1ps
module timer_ctl_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] busRdata, reloadVal, compareVal;
  logic [1:0] okStatus, edgeSel;
  logic countEn, quadMode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  timer_ctl #(.W(W), .XFER_CYCLES(3)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .okStatus(okStatus), .countEn(countEn), .quadMode(quadMode),
    .edgeSel(edgeSel), .reloadVal(reloadVal), .compareVal(compareVal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, the write lands at the next posedge, return at the following negedge
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic void summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] expV;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state, R9 status layout
    check("R1 reloadVal", reloadVal, 32'hFFFF);
    check("R1 compareVal", compareVal, 0);
    check("R1 countEn", countEn, 0);
    check("R1 cfg", {quadMode, edgeSel}, 0);
    rd(3'd0, d); check("R1 ctrl", d, 0);
    rd(3'd4, d); check("R9 status reset", d, 0);
    rd(3'd6, d); check("R9 unused addr", d, 0);

    // R2 writes while disabled
    wr(3'd2, 16'h1234); wr(3'd3, 16'h0055); idle(5);
    check("R2 reload ignored", reloadVal, 32'hFFFF);
    check("R2 compare ignored", compareVal, 0);
    check("R2 no flag", okStatus, 0);

    // R7 cfg accepted while disabled
    wr(3'd1, 16'h0005);
    check("R7 cfg while off", {quadMode, edgeSel}, 3'b110);

    // R6 enable plus start from disabled: start refused
    wr(3'd0, 16'h0003);
    rd(3'd0, d); check("R6 start refused when off", d, 1);
    check("R6 countEn", countEn, 0);

    // R7 cfg locked while enabled
    wr(3'd1, 16'h0002);
    rd(3'd1, d); check("R7 cfg locked", d, 5);

    // R6 start before reload loaded
    wr(3'd0, 16'h0003);
    check("R6 start before load", countEn, 0);

    // R3 reload timing
    wr(3'd2, 16'h00FF); idle(2);
    check("R3 reload flag early", okStatus, 0);
    check("R3 reload value early", reloadVal, 32'hFFFF);
    idle(1);
    check("R3 reload flag", okStatus, 1);
    check("R3 reload value", reloadVal, 32'h00FF);

    // R3 compare timing
    wr(3'd3, 16'h0000); idle(2);
    check("R3 compare flag early", okStatus, 1);
    idle(1);
    check("R3 compare flag", okStatus, 3);
    rd(3'd4, d); check("R9 status both", d, 3);

    // R5 clear masks
    wr(3'd5, 16'h0000); check("R5 clear zero", okStatus, 3);
    wr(3'd5, 16'h0002); check("R5 clear compare", okStatus, 1);
    wr(3'd5, 16'h0001); check("R5 clear reload", okStatus, 0);
    idle(3); check("R5 sticky stays clear", okStatus, 0);

    // R6 start after load
    wr(3'd0, 16'h0003);
    check("R6 countEn", countEn, 1);
    rd(3'd0, d); check("R6 ctrl", d, 3);

    // R4 window sweep: second write k edges after the first
    for (int k = 1; k <= 5; k++) begin
      wr(3'd2, 16'h0100 + k);
      idle(k - 1);
      wr(3'd2, 16'h0200 + k);
      idle(5);
      expV = (k >= 4) ? 16'h0200 + k : 16'h0100 + k;
      check($sformatf("R4 window k=%0d", k), reloadVal, expV);
    end

    // R4 reload and compare independent, back to back
    wr(3'd5, 16'h0003);
    wr(3'd2, 16'h0777); wr(3'd3, 16'h0042); idle(4);
    check("R4 reload indep", reloadVal, 32'h0777);
    check("R4 compare indep", compareVal, 32'h0042);
    check("R4 both flags", okStatus, 3);

    // R8 disable cancels pending transfer
    wr(3'd2, 16'hABCD);
    wr(3'd0, 16'h0000);
    check("R8 flags cleared", okStatus, 0);
    check("R8 countEn", countEn, 0);
    rd(3'd0, d); check("R8 ctrl", d, 0);
    idle(5);
    check("R8 pending dropped", reloadVal, 32'h0777);
    check("R8 no late flag", okStatus, 0);

    // R8 loaded state cleared: re-enable and start without reload
    wr(3'd0, 16'h0001);
    wr(3'd0, 16'h0003);
    check("R8 start needs new load", countEn, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule